// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address and a set of read, write and execute grants, or into a fault code. A caller presents an address, the kind of access it needs, the privilege mode it runs in and a flag that marks untranslated (physical) accesses. The walker takes the request in a single cycle when idle. It then either resolves it at once, for physical accesses, malformed addresses and the kernel direct-map window, or walks a three-level table held in memory.

The walk issues one 8-byte read at a time on a simple request/response port. It holds the request until a response arrives, then checks the returned entry before moving to the next level. The root of the table comes from a base input that is sampled when the request is taken. Pages are 8 KiB. Each level is indexed by a 10-bit slice of the virtual address. The final entry carries per-mode read and write enables and three fault-on-operation bits, which strip grants after the access check.

Top module: `pw_walker`

## Requirements
- R1: While reset is held and after it is released, doneValid and memReqValid are low until a request is taken.
- R2: A request with reqPhys set finishes without a memory read: donePhys equals reqAddr, donePerm is 3'b111 (bit 0 read, bit 1 write, bit 2 execute) and doneFault is low.
- R3: A non-physical address whose bits 63:43 are not all equal to bit 63 ends with doneFault high and faultCode 1 (access violation), with no memory read.
- R4: In kernel mode (reqMode 0), an address with bits 63:43 all one and bits 42:41 equal to 2'b10 finishes without a read, with donePerm 3'b111 and donePhys equal to address bits 39:0, except that address bit 40 appears at bit 43 and bit 40 is zero.
- R5: The same direct-map address from any mode other than 0 ends with faultCode 1.
- R6: The walk reads at most three entries, in order, at base + 8 x index, using the index slices 42:33, 32:23 and 22:13. The first base is ptBase. memReqValid and memReqAddr stay steady until memRspValid.
- R7: A first or second level entry with bit 0 (valid) clear ends the walk with faultCode 0. One with bit 8 (kernel read) clear ends it with faultCode 1. Otherwise the next base is entry bits 63:32 shifted left by 13.
- R8: A third level entry with bit 0 clear gives faultCode 0. A usable one gives donePhys = (entry bits 63:32 << 13) | address bits 12:0.
- R9: The third level entry grants read and execute when bit 8+reqMode is set, and write when bit 12+reqMode is set. If reqNeed is nonzero and shares no bit with those grants, the result is faultCode 1.
- R10: Entry bits 1, 2 and 3 then clear the read, write and execute grants. If reqNeed is nonzero and no needed grant is left, faultCode is 3 when execute was needed, otherwise 4 when write was needed, otherwise 2.
- R11: doneValid is a one-cycle pulse. It comes one cycle after the accepting edge for a request resolved without reads, and one cycle after the edge that takes the last response for a walk. On a fault donePerm and donePhys are zero. A request with reqNeed 0 succeeds with the stripped grants.
- R12: reqValid is ignored while a request is in progress or being reported, and no further read or result follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqAddr | input | 64 | Virtual address |
| reqNeed | input | 3 | Needed access: bit 0 read, bit 1 write, bit 2 execute |
| reqMode | input | 2 | Privilege mode index, 0 is kernel |
| reqPhys | input | 1 | Untranslated access |
| ptBase | input | 64 | Physical base of the first level table |
| memReqValid | output | 1 | Entry read request |
| memReqAddr | output | 64 | Entry read address |
| memRspValid | input | 1 | Entry read data valid |
| memRspData | input | 64 | Entry read data |
| doneValid | output | 1 | Result strobe |
| donePhys | output | 64 | Physical address |
| donePerm | output | 3 | Granted access, same bit order as reqNeed |
| doneFault | output | 1 | Request failed |
| faultCode | output | 3 | 0 not valid, 1 access violation, 2 fault on read, 3 fault on execute, 4 fault on write |

## Verification
Requests that need no reads must report on the first falling edge after the accepting clock edge. The bench samples there and counts a later strobe as a failure. For walks, the responding memory model records the cycle in which it raised each response. The result is checked on the falling edge one cycle after the last response, and the entry addresses are checked as each request is answered. After every result the bench watches two more cycles to confirm that no second strobe or stray read follows. Replies come after random delays of zero to two cycles, so the hold of the request is exercised as well.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int LEVELS = 3;
  localparam int PTE_W = 64;
  localparam int PFN_LSB = 32;
  localparam int PTE_VALID = 0;
  localparam int PTE_FO_LSB = 1;
  localparam int PTE_KRE = 8;
  localparam int PTE_KWE = 12;
  localparam int PERM_READ = 0;
  localparam int PERM_WRITE = 1;
  localparam int PERM_EXEC = 2;
  localparam logic [2:0] PERM_ALL = 3'b111;
  localparam logic [1:0] MODE_KERNEL = 2'd0;

  typedef enum logic [2:0] {
    FC_NOTVALID = 3'd0,
    FC_ACCESS   = 3'd1,
    FC_ON_READ  = 3'd2,
    FC_ON_EXEC  = 3'd3,
    FC_ON_WRITE = 3'd4
  } faultCode_e;

  typedef struct packed {
    logic       loadReq;
    logic       takeEntry;
    logic [1:0] level;
  } walkCtl_t;
endpackage

// File: rtl/pw_datapath.sv
module pw_datapath
  import pw_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int VA_BITS   = 43,
  parameter int PAGE_BITS = 13,
  parameter int IDX_W     = 10,
  parameter int SP_SRC    = 40,
  parameter int SP_DST    = 43
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walkCtl_t          ctl,
  input  logic              doneValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqNeed,
  input  logic [1:0]        reqMode,
  input  logic              reqPhys,
  input  logic [ADDR_W-1:0] ptBase,
  input  logic [PTE_W-1:0]  memRspData,
  output logic              immHit,
  output logic              entryStop,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] donePhys,
  output logic [2:0]        donePerm,
  output logic              doneFault,
  output logic [2:0]        faultCode
);
  localparam int HI_W = ADDR_W - VA_BITS;
  localparam int ENTRY_SHIFT = 3;

  logic [ADDR_W-1:0] addrQ, baseQ, physQ;
  logic [2:0]        needQ, permQ;
  logic [1:0]        modeQ;
  logic              physReqQ, faultQ;
  faultCode_e        codeQ;

  logic [IDX_W-1:0] lvlIdx [LEVELS];
  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : gIdx
      assign lvlIdx[g] = addrQ[PAGE_BITS + IDX_W*(LEVELS-1-g) +: IDX_W];
    end
  endgenerate

  assign memReqAddr = baseQ + ADDR_W'({lvlIdx[ctl.level], {ENTRY_SHIFT{1'b0}}});

  // immediate resolution: physical, malformed, direct-map window
  logic              signOk, superHit, immFault;
  logic [ADDR_W-1:0] immPhys;
  logic [2:0]        immPerm;
  faultCode_e        immCode;

  always_comb begin
    signOk   = reqAddr[ADDR_W-1:VA_BITS] == {HI_W{reqAddr[ADDR_W-1]}};
    superHit = reqAddr[ADDR_W-1] && (reqAddr[VA_BITS-1 -: 2] == 2'b10);
    immHit   = reqPhys || !signOk || superHit;
    immPhys  = '0;
    immPerm  = '0;
    immFault = 1'b0;
    immCode  = FC_NOTVALID;
    if (reqPhys) begin
      immPhys = reqAddr;
      immPerm = PERM_ALL;
    end else if (!signOk || (superHit && reqMode != MODE_KERNEL)) begin
      immFault = 1'b1;
      immCode  = FC_ACCESS;
    end else if (superHit) begin
      immPhys = ADDR_W'(reqAddr[SP_SRC-1:0]) | (ADDR_W'(reqAddr[SP_SRC]) << SP_DST);
      immPerm = PERM_ALL;
    end
  end

  // entry evaluation
  logic              isLeaf, rdEn, wrEn, entFault;
  logic [2:0]        grant, kept, entPerm;
  logic [ADDR_W-1:0] nextBase, entPhys;
  faultCode_e        entCode;

  always_comb begin
    isLeaf   = ctl.level == 2'(LEVELS-1);
    rdEn     = memRspData[PTE_KRE + int'(modeQ)];
    wrEn     = memRspData[PTE_KWE + int'(modeQ)];
    grant    = {rdEn, wrEn, rdEn};
    kept     = grant & ~memRspData[PTE_FO_LSB +: 3];
    nextBase = ADDR_W'(memRspData[PTE_W-1:PFN_LSB]) << PAGE_BITS;
    entFault = 1'b1;
    entCode  = FC_NOTVALID;
    entPerm  = '0;
    entPhys  = '0;
    if (!memRspData[PTE_VALID]) begin
      entCode = FC_NOTVALID;
    end else if (!isLeaf) begin
      entFault = !memRspData[PTE_KRE];
      entCode  = FC_ACCESS;
    end else if (needQ != 3'b000 && (grant & needQ) == 3'b000) begin
      entCode = FC_ACCESS;
    end else if (needQ != 3'b000 && (kept & needQ) == 3'b000) begin
      entCode = needQ[PERM_EXEC]  ? FC_ON_EXEC :
                needQ[PERM_WRITE] ? FC_ON_WRITE : FC_ON_READ;
    end else begin
      entFault = 1'b0;
      entPerm  = kept;
      entPhys  = nextBase | ADDR_W'(addrQ[PAGE_BITS-1:0]);
    end
    entryStop = entFault;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ    <= '0;
      baseQ    <= '0;
      needQ    <= '0;
      modeQ    <= '0;
      physReqQ <= 1'b0;
      physQ    <= '0;
      permQ    <= '0;
      faultQ   <= 1'b0;
      codeQ    <= FC_NOTVALID;
    end else if (ctl.loadReq) begin
      addrQ    <= reqAddr;
      baseQ    <= ptBase;
      needQ    <= reqNeed;
      modeQ    <= reqMode;
      physReqQ <= reqPhys;
      physQ    <= immPhys;
      permQ    <= immPerm;
      faultQ   <= immFault;
      codeQ    <= immCode;
    end else if (ctl.takeEntry) begin
      if (isLeaf || entFault) begin
        physQ  <= entPhys;
        permQ  <= entPerm;
        faultQ <= entFault;
        codeQ  <= entCode;
      end else begin
        baseQ <= nextBase;
      end
    end
  end

  assign donePhys  = physQ;
  assign donePerm  = permQ;
  assign doneFault = faultQ;
  assign faultCode = codeQ;

  assert_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid && !doneFault && needQ != 3'b000 |-> (donePerm & needQ) != 3'b000);
  assert_code_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid && doneFault |-> faultCode <= FC_ON_WRITE);
  assert_phys_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid && physReqQ |-> !doneFault && donePhys == addrQ && donePerm == PERM_ALL);
  assert_fault_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid && doneFault |-> donePerm == 3'b000 && donePhys == '0);
endmodule

// File: rtl/pw_control.sv
module pw_control
  import pw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reqValid,
  input  logic     immHit,
  input  logic     entryStop,
  input  logic     memRspValid,
  output walkCtl_t ctl,
  output logic     memReqValid,
  output logic     doneValid
);
  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_DONE} state_e;
  state_e     stateQ, stateD;
  logic [1:0] levelQ, levelD;

  always_comb begin
    stateD        = stateQ;
    levelD        = levelQ;
    ctl.loadReq   = 1'b0;
    ctl.takeEntry = 1'b0;
    ctl.level     = levelQ;
    memReqValid   = 1'b0;
    doneValid     = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.loadReq = 1'b1;
          levelD      = 2'd0;
          stateD      = immHit ? ST_DONE : ST_WALK;
        end
      end
      ST_WALK: begin
        memReqValid = 1'b1;
        if (memRspValid) begin
          ctl.takeEntry = 1'b1;
          if (entryStop || levelQ == 2'(LEVELS-1)) stateD = ST_DONE;
          else levelD = levelQ + 2'd1;
        end
      end
      ST_DONE: begin
        doneValid = 1'b1;
        stateD    = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      levelQ <= 2'd0;
    end else begin
      stateQ <= stateD;
      levelQ <= levelD;
    end
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !doneValid);
  assert_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.loadReq && immHit |=> doneValid && !memReqValid);
  assert_req_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid && !memRspValid |=> memReqValid);
endmodule

// File: rtl/pw_walker.sv
module pw_walker
  import pw_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int VA_BITS   = 43,
  parameter int PAGE_BITS = 13,
  parameter int IDX_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqNeed,
  input  logic [1:0]        reqMode,
  input  logic              reqPhys,
  input  logic [ADDR_W-1:0] ptBase,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [PTE_W-1:0]  memRspData,
  output logic              doneValid,
  output logic [ADDR_W-1:0] donePhys,
  output logic [2:0]        donePerm,
  output logic              doneFault,
  output logic [2:0]        faultCode
);
  walkCtl_t ctl;
  logic     immHit, entryStop;

  pw_control uCtrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .immHit(immHit),
    .entryStop(entryStop), .memRspValid(memRspValid), .ctl(ctl),
    .memReqValid(memReqValid), .doneValid(doneValid)
  );

  pw_datapath #(
    .ADDR_W(ADDR_W), .VA_BITS(VA_BITS), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)
  ) uDp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .doneValid(doneValid),
    .reqAddr(reqAddr), .reqNeed(reqNeed), .reqMode(reqMode), .reqPhys(reqPhys),
    .ptBase(ptBase), .memRspData(memRspData), .immHit(immHit), .entryStop(entryStop),
    .memReqAddr(memReqAddr), .donePhys(donePhys), .donePerm(donePerm),
    .doneFault(doneFault), .faultCode(faultCode)
  );

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid && !memRspValid |=> $stable(memReqAddr));
endmodule

// File: tb/pw_walker_test.sv
module pw_walker_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, reqValid, reqPhys, memReqValid, memRspValid, doneValid, doneFault;
  logic [63:0] reqAddr, ptBase, memReqAddr, memRspData, donePhys;
  logic [2:0]  reqNeed, donePerm, faultCode;
  logic [1:0]  reqMode;

  pw_walker uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr), .reqNeed(reqNeed),
    .reqMode(reqMode), .reqPhys(reqPhys), .ptBase(ptBase), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .doneValid(doneValid), .donePhys(donePhys), .donePerm(donePerm),
    .doneFault(doneFault), .faultCode(faultCode)
  );

  int checks = 0, errors = 0, cycle = 0;
  always @(posedge clk) cycle++;

  logic [63:0] pte [3];
  logic [63:0] expAddr [3];
  int rdCount = 0, lastRsp = 0, waitCnt = 0;
  logic        eFault;
  logic [2:0]  eCode, ePerm;
  logic [63:0] ePhys;
  int          eReads;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // memory model: answers after 0..2 idle cycles, checks entry addresses (R6)
  always @(negedge clk) begin
    if (memRspValid) memRspValid <= 1'b0;
    else if (memReqValid) begin
      if (waitCnt == 0) begin
        if (rdCount >= 3) chk("R6", "extra read", 64'(rdCount), 64'd2);
        else begin
          chk("R6", "entry address", memReqAddr, expAddr[rdCount]);
          memRspData <= pte[rdCount];
        end
        rdCount++;
        lastRsp = cycle;
        memRspValid <= 1'b1;
        waitCnt = int'($urandom % 3);
      end else waitCnt--;
    end
  end

  function automatic void model(logic [63:0] a, logic [2:0] need, logic [1:0] mode,
                                logic ph, logic [63:0] base);
    logic [63:0] b;
    logic [63:0] e;
    logic [2:0] g, k;
    logic r, w;
    eFault = 1'b0; eCode = 3'd0; ePerm = 3'b000; ePhys = 64'd0; eReads = 0;
    if (ph) begin ePhys = a; ePerm = 3'b111; return; end
    if (a[63:43] != {21{a[63]}}) begin eFault = 1'b1; eCode = 3'd1; return; end
    if (a[63] && a[42:41] == 2'b10) begin
      if (mode != 2'd0) begin eFault = 1'b1; eCode = 3'd1; return; end
      ePhys = {24'd0, a[39:0]} | (64'(a[40]) << 43);
      ePerm = 3'b111;
      return;
    end
    b = base;
    for (int lv = 0; lv < 3; lv++) begin
      expAddr[lv] = b + {51'd0, a[13 + 10*(2-lv) +: 10], 3'b000};
      eReads = lv + 1;
      e = pte[lv];
      if (!e[0]) begin eFault = 1'b1; eCode = 3'd0; return; end
      if (lv < 2) begin
        if (!e[8]) begin eFault = 1'b1; eCode = 3'd1; return; end
        b = {19'd0, e[63:32], 13'd0};
      end else begin
        r = e[8 + int'(mode)];
        w = e[12 + int'(mode)];
        g = {r, w, r};
        if (need != 3'b000 && (g & need) == 3'b000) begin eFault = 1'b1; eCode = 3'd1; return; end
        k = g & ~e[3:1];
        if (need != 3'b000 && (k & need) == 3'b000) begin
          eFault = 1'b1;
          eCode = need[2] ? 3'd3 : need[1] ? 3'd4 : 3'd2;
          return;
        end
        ePerm = k;
        ePhys = {19'd0, e[63:32], a[12:0]};
      end
    end
  endfunction

  task automatic runWalk(string tag, logic [63:0] a, logic [2:0] need, logic [1:0] mode,
                         logic ph, logic [63:0] base, logic poke);
    int n;
    bit got;
    model(a, need, mode, ph, base);
    rdCount = 0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqNeed = need; reqMode = mode; reqPhys = ph; ptBase = base;
    @(negedge clk);
    // R12: a second request while busy must be ignored
    reqValid = poke; reqAddr = ~a; reqPhys = ~ph; reqMode = ~mode; ptBase = ~base;
    got = 1'b0;
    for (n = 0; n < 60; n++) begin
      if (doneValid) begin got = 1'b1; break; end
      @(negedge clk);
      reqValid = 1'b0;
    end
    reqValid = 1'b0;
    chk(tag, "done seen", 64'(got), 64'd1);
    if (eReads == 0) chk("R11", "done latency", 64'(n), 64'd0);
    else chk("R11", "done after last reply", 64'(cycle), 64'(lastRsp + 1));
    chk(tag, "reads", 64'(rdCount), 64'(eReads));
    chk(tag, "fault", 64'(doneFault), 64'(eFault));
    if (eFault) chk(tag, "code", 64'(faultCode), 64'(eCode));
    chk(tag, "phys", donePhys, ePhys);
    chk(tag, "perm", 64'(donePerm), 64'(ePerm));
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R12", "quiet after done", {62'd0, doneValid, memReqValid}, 64'd0);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] walkA;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; reqValid = 1'b0; reqAddr = '0; reqNeed = '0; reqMode = '0;
    reqPhys = 1'b0; ptBase = '0; memRspValid = 1'b0; memRspData = '0;
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {62'd0, doneValid, memReqValid}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "outputs after reset", {62'd0, doneValid, memReqValid}, 64'd0);

    walkA = 64'h0000_0123_4567_89AB;
    runWalk("R2", 64'hDEAD_BEEF_0000_1234, 3'b010, 2'd3, 1'b1, 64'h1000, 1'b1);
    runWalk("R3", 64'h0000_8000_0000_0000, 3'b001, 2'd0, 1'b0, 64'h1000, 1'b0);
    runWalk("R3", 64'hFFFF_7000_0000_0000, 3'b001, 2'd0, 1'b0, 64'h1000, 1'b1);
    runWalk("R4", 64'hFFFF_FD12_3456_7890, 3'b100, 2'd0, 1'b0, 64'h1000, 1'b1);
    runWalk("R4", 64'hFFFF_FC12_3456_7890, 3'b001, 2'd0, 1'b0, 64'h1000, 1'b0);
    runWalk("R5", 64'hFFFF_FD12_3456_7890, 3'b001, 2'd2, 1'b0, 64'h1000, 1'b0);

    pte[0] = 64'h0000_0040_0000_0101; pte[1] = 64'h0000_0050_0000_0101;
    pte[2] = 64'h0000_0077_0000_1101;
    runWalk("R6", walkA, 3'b010, 2'd0, 1'b0, 64'h0002_0000, 1'b1);
    runWalk("R8", walkA, 3'b001, 2'd0, 1'b0, 64'h0002_0000, 1'b0);
    pte[0] = 64'h0000_0040_0000_0100;
    runWalk("R7", walkA, 3'b001, 2'd0, 1'b0, 64'h0002_0000, 1'b1);
    pte[0] = 64'h0000_0040_0000_0101; pte[1] = 64'h0000_0050_0000_0001;
    runWalk("R7", walkA, 3'b001, 2'd0, 1'b0, 64'h0002_0000, 1'b0);
    pte[1] = 64'h0000_0050_0000_0101; pte[2] = 64'h0000_0077_0000_1100;
    runWalk("R8", walkA, 3'b001, 2'd0, 1'b0, 64'h0002_0000, 1'b0);
    pte[2] = 64'h0000_0077_0000_1101;
    runWalk("R9", walkA, 3'b001, 2'd3, 1'b0, 64'h0002_0000, 1'b0);
    pte[2] = 64'h0000_0077_0000_0901;
    runWalk("R9", walkA, 3'b100, 2'd3, 1'b0, 64'h0002_0000, 1'b0);
    runWalk("R9", walkA, 3'b010, 2'd3, 1'b0, 64'h0002_0000, 1'b0);
    pte[2] = 64'h0000_0077_0000_1103;
    runWalk("R10", walkA, 3'b001, 2'd0, 1'b0, 64'h0002_0000, 1'b0);
    pte[2] = 64'h0000_0077_0000_1109;
    runWalk("R10", walkA, 3'b100, 2'd0, 1'b0, 64'h0002_0000, 1'b0);
    pte[2] = 64'h0000_0077_0000_1105;
    runWalk("R10", walkA, 3'b010, 2'd0, 1'b0, 64'h0002_0000, 1'b0);
    runWalk("R10", walkA, 3'b011, 2'd0, 1'b0, 64'h0002_0000, 1'b0);
    pte[2] = 64'h0000_0077_0000_110F;
    runWalk("R11", walkA, 3'b000, 2'd0, 1'b0, 64'h0002_0000, 1'b1);

    for (int it = 0; it < 400; it++) begin
      logic [63:0] a, b;
      logic [40:0] low;
      int sel;
      sel = int'($urandom % 8);
      low = rnd64()[40:0];
      if (sel == 1) a = rnd64();
      else if (sel == 2) a = {21'h1F_FFFF, 2'b10, low};
      else begin
        a = rnd64();
        a = {{21{a[42]}}, a[42:0]};
      end
      for (int lv = 0; lv < 3; lv++) begin
        pte[lv] = rnd64();
        pte[lv][0] = ($urandom % 10) != 0;
        if (lv < 2) pte[lv][8] = ($urandom % 8) != 0;
      end
      b = {rnd64()[63:3], 3'b000};
      runWalk("R6", a, 3'($urandom), 2'($urandom), sel == 0, b, 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule